// File: doc/BRIEF.md
# Recursive Vertical-Crosswise Unsigned Multiplier

This block multiplies two unsigned W-bit operands and returns the full 2W-bit product in the same cycle. It has no clock and no state. It is meant to be placed inside a datapath that registers the operands and the product around it. W must be a power of two, at least 2. Any other value stops elaboration.

The product is built by recursion. The smallest case is a 2x2 cell made of four AND terms and two half adders. A W-bit level splits each operand into a high half and a low half. It forms the four half-width cross products with smaller copies of itself, and then adds them:

- the low-by-low product sits at weight 0;
- the two mixed products sit at weight W/2;
- the high-by-high product sits at weight W.

The lowest W/2 bits of the low-by-low product pass straight through. A single adder merges all remaining terms into the upper part of the result.

Top module: `vcx_mul`

## Requirements
- R1: For W = 32, `prod` equals the exact 64-bit unsigned product of `opa` and `opb` for any operand pair, including 0, 1, all-ones and alternating-bit patterns.
- R2: For W = 32, multiplying 0xFFFFFFFF by 0xFFFFFFFF yields 0xFFFFFFFE00000001.
- R3: The upper W bits of `prod` are never all ones, because the largest product (2^W-1)^2 fits in 2W bits and the combining adders never overflow.
- R4: If either operand is zero, `prod` is zero.
- R5: If `opa` equals 1, `prod` equals `opb` zero-extended to 2W bits.
- R6: With W = 4, `prod` is correct for all 256 operand pairs.
- R7: With W = 8, `prod` is correct for all 65536 operand pairs.
- R8: With W = 2, which is the leaf cell alone, `prod` is correct for all 16 operand pairs. Product bit 1 is the sum bit of a1&b0 plus a0&b1. Bits 3:2 are a1&b1 plus the carry from that sum.
- R9: At every width, bit 0 of `prod` equals `opa[0] & opb[0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | W | Multiplicand, unsigned |
| opb | input | W | Multiplier, unsigned |
| prod | output | 2*W | Full unsigned product |

## Verification
The block is combinational, so a fault inside it shows at `prod` as soon as the operands settle. It does not wait for later cycles.

A wrong gate in the leaf cell damages every product whose operands reach the affected quadrant. A wrong weight or carry in a combining adder shifts whole columns of the result, so it shows on simple patterns such as all-ones.

Exhaustive sweeps at widths 2, 4 and 8 exercise every leaf and every combining level in the small configurations. Mixed random and corner operands at width 32 cover the deepest carry chains.

// File: rtl/vcx_mul.sv
module vcx_mul #(
  parameter int W = 32
) (
  input  logic [W-1:0]   opa,
  input  logic [W-1:0]   opb,
  output logic [2*W-1:0] prod
);
  localparam bit WIDTH_OK = (W >= 2) && ((W & (W - 1)) == 0);
  localparam int HW = (W >= 2) ? W / 2 : 1;

  generate
    if (!WIDTH_OK) begin : g_bad
      $error("vcx_mul: W must be a power of two of at least 2");
      assign prod = '0;
    end else if (W == 2) begin : g_leaf
      logic t00, t01, t10, t11;
      logic s1, c1, s2, c2;
      assign t00 = opa[0] & opb[0];
      assign t10 = opa[1] & opb[0];
      assign t01 = opa[0] & opb[1];
      assign t11 = opa[1] & opb[1];
      assign s1 = t10 ^ t01;
      assign c1 = t10 & t01;
      assign s2 = t11 ^ c1;
      assign c2 = t11 & c1;
      assign prod = {c2, s2, s1, t00};
    end else begin : g_split
      logic [W-1:0]    p_ll, p_hl, p_lh, p_hh;
      logic [W:0]      mid;
      logic [3*HW-1:0] upper;

      vcx_mul #(.W(HW)) u_ll (.opa(opa[HW-1:0]), .opb(opb[HW-1:0]), .prod(p_ll));
      vcx_mul #(.W(HW)) u_hl (.opa(opa[W-1:HW]), .opb(opb[HW-1:0]), .prod(p_hl));
      vcx_mul #(.W(HW)) u_lh (.opa(opa[HW-1:0]), .opb(opb[W-1:HW]), .prod(p_lh));
      vcx_mul #(.W(HW)) u_hh (.opa(opa[W-1:HW]), .opb(opb[W-1:HW]), .prod(p_hh));

      assign mid   = {1'b0, p_hl} + {1'b0, p_lh};
      assign upper = {p_hh, p_ll[W-1:HW]} + {{(HW-1){1'b0}}, mid};
      assign prod  = {upper, p_ll[HW-1:0]};
    end
  endgenerate
endmodule

// File: rtl/vcx_mul_chk.sv
module vcx_mul_chk #(
  parameter int W = 32
) (
  input logic [W-1:0]   opa,
  input logic [W-1:0]   opb,
  input logic [2*W-1:0] prod
);
  always_comb begin
    assert_no_overflow_R3: assert (prod[2*W-1:W] != {W{1'b1}});
    if (opa == '0 || opb == '0) begin
      assert_zero_operand_R4: assert (prod == '0);
    end
    if (opa == W'(1)) begin
      assert_unit_operand_R5: assert (prod == {{W{1'b0}}, opb});
    end
    assert_low_bit_R9: assert (prod[0] == (opa[0] & opb[0]));
  end
endmodule

bind vcx_mul vcx_mul_chk #(.W(W)) u_chk (.opa(opa), .opb(opb), .prod(prod));

// File: tb/vcx_mul_test.sv
`timescale 1ns/1ps
module vcx_mul_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] a32 = '0, b32 = '0;
  logic [63:0] p32;
  logic [7:0]  a8 = '0, b8 = '0;
  logic [15:0] p8;
  logic [3:0]  a4 = '0, b4 = '0;
  logic [7:0]  p4;
  logic [1:0]  a2 = '0, b2 = '0;
  logic [3:0]  p2;

  vcx_mul #(.W(32)) uut (.opa(a32), .opb(b32), .prod(p32));
  vcx_mul #(.W(8))  u8  (.opa(a8),  .opb(b8),  .prod(p8));
  vcx_mul #(.W(4))  u4  (.opa(a4),  .opb(b4),  .prod(p4));
  vcx_mul #(.W(2))  u2  (.opa(a2),  .opb(b2),  .prod(p2));

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic try32(input string req, input logic [31:0] x, input logic [31:0] y);
    @(posedge clk);
    a32 = x;
    b32 = y;
    @(negedge clk);
    check(req, p32, {32'd0, x} * {32'd0, y});
    if (x == 32'd0 || y == 32'd0) check("R4", p32, 64'd0);
    if (x == 32'd1) check("R5", p32, {32'd0, y});
    check("R9", {63'd0, p32[0]}, {63'd0, x[0] & y[0]});
    check("R3", {63'd0, p32[63:32] == 32'hFFFFFFFF}, 64'd0);
  endtask

  initial begin
    @(negedge clk);
    check("R4 idle zero", p32, 64'd0);

    try32("R2", 32'hFFFFFFFF, 32'hFFFFFFFF);
    check("R2", p32, 64'hFFFFFFFE00000001);
    try32("R4", 32'd0, 32'h12345678);
    try32("R4", 32'h89ABCDEF, 32'd0);
    try32("R5", 32'd1, 32'hDEADBEEF);
    try32("R5", 32'd1, 32'hFFFFFFFF);
    try32("R1", 32'hAAAAAAAA, 32'h55555555);
    try32("R1", 32'h55555555, 32'h55555555);
    try32("R1", 32'hAAAAAAAA, 32'hFFFFFFFF);
    try32("R1", 32'h80000000, 32'h80000000);
    try32("R1", 32'h0000FFFF, 32'hFFFF0000);
    for (int k = 0; k < 3000; k++)
      try32("R1", $urandom, $urandom);

    for (int i = 0; i < 65536; i++) begin
      @(posedge clk);
      a8 = i[15:8];
      b8 = i[7:0];
      a4 = i[7:4];
      b4 = i[3:0];
      a2 = i[3:2];
      b2 = i[1:0];
      @(negedge clk);
      check("R7", {48'd0, p8}, 64'(int'(i[15:8]) * int'(i[7:0])));
      if (i < 256)
        check("R6", {56'd0, p4}, 64'(int'(i[7:4]) * int'(i[3:0])));
      if (i < 16) begin
        check("R8", {60'd0, p2}, 64'(int'(i[3:2]) * int'(i[1:0])));
        check("R9", {63'd0, p2[0]}, {63'd0, i[2] & i[0]});
      end
    end
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule